// File: doc/BRIEF.md
# Dual-Bank Checkerboard Address Generator

This unit produces one read address per cycle for each of two data memories. It holds two address pointers, a pair of ring-buffer bounds, a row pitch and two parity flags. Linear streams use a plain post-increment on the first pointer and a ring-buffer post-increment on the second pointer. This lets a filter walk a coefficient table and a circular sample buffer in lock step.

For image work, the frame buffer is split across the two memories in a checkerboard pattern, so that any two horizontally or vertically adjacent pixels sit in different banks. A set-up sequence is used first: load the pixel column and row, then add the row offset and the two bank base addresses. After that, the checkerboard operations read both banks together. The parity of the column and of the row decides which bank needs a one-word correction. The stepping form of the operation also moves both pointers down one row.

The addresses shown in a cycle are derived from the register contents held before that cycle's update. They depend combinationally on the operation code presented in that cycle. An operation is applied on every clock edge. All reset and update behaviour is synchronous, with an active-high reset.

Top module: `ckbd_agu`

## Requirements
- R1: While `rst` is high, every register (both pointers, ring start, ring end, pitch, both parity flags) is cleared at the clock edge. After reset, a hold operation shows address 0 on both banks.
- R2: Operation code 0 (hold) and the unused codes 9 to 15 leave every register unchanged. While no checkerboard operation is presented, bank 0 shows pointer 0 and bank 1 shows pointer 1.
- R3: Operation code 1 (stream step) shows both pointers as the addresses and then increments pointer 0 by one.
- R4: Under operation code 1, pointer 1 is set to the ring start value if it equals the ring end value, and otherwise is incremented by one.
- R5: Operation code 2 loads the ring start from operand A. Operation code 3 loads the ring end from operand A.
- R6: Operation code 4 (set position) loads both pointers with operand A shifted right by one bit. It latches the column flag as bit 0 of operand A and the row flag as bit 0 of operand B.
- R7: Operation code 5 (row offset) adds operand A to both pointers and loads the pitch register from operand B.
- R8: Operation code 6 (bases) adds operand A to pointer 0 and operand B to pointer 1.
- R9: Operation code 7 (checkerboard read) shows two addresses: bank 0 shows pointer 0 plus one when the column flag is 1 and the row flag is 0, and bank 1 shows pointer 1 plus one when both flags are 1. No register changes.
- R10: Operation code 8 (checkerboard read and next row) shows the R9 addresses plus one on each bank. It then adds the pitch to both pointers and inverts the row flag.
- R11: All address arithmetic is modulo 2^AW. A pointer at the all-ones value steps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code for this cycle |
| opnd_a_i | input | AW | First register-file operand (column, row offset, base 0, ring bound) |
| opnd_b_i | input | AW | Second register-file operand (row, pitch, base 1) |
| bank0_addr_o | output | AW | Address for memory bank 0 |
| bank1_addr_o | output | AW | Address for memory bank 1 |

## Verification
The bench builds the unit with its default width of 16 bits. At that width, the wrap of a pointer from all ones to zero takes only two set-up operations, and the ring-buffer boundary takes a handful of steps. Row stepping is run for several rows with both column parities, so all four combinations of the flags reach the bank offset logic. The pitch used is a multiple of 64, matching the alignment of the frame-buffer bases.

// File: rtl/ckbd_agu_pkg.sv
package ckbd_agu_pkg;

    typedef enum logic [3:0] {
        OP_HOLD      = 4'd0,
        OP_STEP      = 4'd1,
        OP_LD_START  = 4'd2,
        OP_LD_END    = 4'd3,
        OP_SET_XY    = 4'd4,
        OP_ADD_PITCH = 4'd5,
        OP_ADD_BASE  = 4'd6,
        OP_CB_STAY   = 4'd7,
        OP_CB_STEP   = 4'd8
    } agu_op_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/ckbd_ring_step.sv
module ckbd_ring_step #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    output logic [AW-1:0] nxt_o
);
    logic at_end;

    always_comb begin
        at_end = (ptr_i == hi_i);
        nxt_o  = at_end ? lo_i : ptr_i + AW'(1);
    end
endmodule

// File: rtl/ckbd_bank_offset.sv
module ckbd_bank_offset #(
    parameter int unsigned AW   = 16,
    parameter int unsigned BANK = 0
) (
    input  logic [AW-1:0] ptr_i,
    input  logic          xm_i,
    input  logic          ym_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);
    logic par;

    generate
        if (BANK == 0) begin : g_even_row
            assign par = xm_i & ~ym_i;
        end else begin : g_odd_row
            assign par = xm_i & ym_i;
        end
    endgenerate

    assign addr_o = ptr_i + AW'(step_i) + AW'(par);
endmodule

// File: rtl/ckbd_agu.sv
module ckbd_agu
    import ckbd_agu_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op_i,
    input  logic [AW-1:0] opnd_a_i,
    input  logic [AW-1:0] opnd_b_i,
    output logic [AW-1:0] bank0_addr_o,
    output logic [AW-1:0] bank1_addr_o
);
    localparam int unsigned NB = NUM_BANKS;

    typedef struct packed {
        logic [AW-1:0] ar0;
        logic [AW-1:0] ar1;
        logic [AW-1:0] ring_lo;
        logic [AW-1:0] ring_hi;
        logic [AW-1:0] pitch;
        logic          xm;
        logic          ym;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [AW-1:0] ring_nxt;
    logic          is_cb;
    logic          is_step;
    logic [AW-1:0] ptr     [NB];
    logic [AW-1:0] cb_addr [NB];
    logic [AW-1:0] bank_addr [NB];

    // plain views of state for the bound checker
    logic [AW-1:0] ar0_q, ar1_q, ring_lo_q, ring_hi_q, pitch_q;
    logic          xm_q, ym_q;

    assign ar0_q     = st_q.ar0;
    assign ar1_q     = st_q.ar1;
    assign ring_lo_q = st_q.ring_lo;
    assign ring_hi_q = st_q.ring_hi;
    assign pitch_q   = st_q.pitch;
    assign xm_q      = st_q.xm;
    assign ym_q      = st_q.ym;

    assign ptr[0] = st_q.ar0;
    assign ptr[1] = st_q.ar1;

    ckbd_ring_step #(.AW(AW)) u_ring (
        .ptr_i (st_q.ar1),
        .lo_i  (st_q.ring_lo),
        .hi_i  (st_q.ring_hi),
        .nxt_o (ring_nxt)
    );

    assign is_step = (op_i == OP_CB_STEP);
    assign is_cb   = (op_i == OP_CB_STAY) || is_step;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            ckbd_bank_offset #(.AW(AW), .BANK(b)) u_off (
                .ptr_i  (ptr[b]),
                .xm_i   (st_q.xm),
                .ym_i   (st_q.ym),
                .step_i (is_step),
                .addr_o (cb_addr[b])
            );
            assign bank_addr[b] = is_cb ? cb_addr[b] : ptr[b];
        end
    endgenerate

    assign bank0_addr_o = bank_addr[0];
    assign bank1_addr_o = bank_addr[1];

    always_comb begin
        st_d = st_q;
        case (op_i)
            OP_STEP: begin
                st_d.ar0 = st_q.ar0 + AW'(1);
                st_d.ar1 = ring_nxt;
            end
            OP_LD_START: st_d.ring_lo = opnd_a_i;
            OP_LD_END:   st_d.ring_hi = opnd_a_i;
            OP_SET_XY: begin
                st_d.ar0 = opnd_a_i >> 1;
                st_d.ar1 = opnd_a_i >> 1;
                st_d.xm  = opnd_a_i[0];
                st_d.ym  = opnd_b_i[0];
            end
            OP_ADD_PITCH: begin
                st_d.ar0   = st_q.ar0 + opnd_a_i;
                st_d.ar1   = st_q.ar1 + opnd_a_i;
                st_d.pitch = opnd_b_i;
            end
            OP_ADD_BASE: begin
                st_d.ar0 = st_q.ar0 + opnd_a_i;
                st_d.ar1 = st_q.ar1 + opnd_b_i;
            end
            OP_CB_STEP: begin
                st_d.ar0 = st_q.ar0 + st_q.pitch;
                st_d.ar1 = st_q.ar1 + st_q.pitch;
                st_d.ym  = ~st_q.ym;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ckbd_agu_chk.sv
module ckbd_agu_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    op_i,
    input logic [AW-1:0] opnd_a_i,
    input logic [AW-1:0] opnd_b_i,
    input logic [AW-1:0] bank0_addr_o,
    input logic [AW-1:0] bank1_addr_o,
    input logic [AW-1:0] ar0_q,
    input logic [AW-1:0] ar1_q,
    input logic [AW-1:0] ring_lo_q,
    input logic [AW-1:0] ring_hi_q,
    input logic [AW-1:0] pitch_q,
    input logic          xm_q,
    input logic          ym_q
);
    logic [AW-1:0] d0, d1, dsum;
    assign d0   = bank0_addr_o - ar0_q;
    assign d1   = bank1_addr_o - ar1_q;
    assign dsum = d0 + d1;

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |=> (ar0_q == $past(ar0_q) && ar1_q == $past(ar1_q)
                            && pitch_q == $past(pitch_q) && ym_q == $past(ym_q)));

    assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd1 && ar1_q == ring_hi_q) |=> (ar1_q == $past(ring_lo_q)));

    assert_setxy_load_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd4) |=> (xm_q == $past(opnd_a_i[0]) && ym_q == $past(opnd_b_i[0])
                            && ar0_q == ($past(opnd_a_i) >> 1)));

    assert_pitch_load_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd5) |=> (pitch_q == $past(opnd_b_i)));

    assert_cb_one_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |-> (dsum <= AW'(1)));

    assert_cb_stay_still_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |=> ($stable(ar0_q) && $stable(ar1_q) && $stable(ym_q)));

    assert_cb_next_row_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8) |=> (ym_q != $past(ym_q)
                            && ar0_q == $past(ar0_q) + $past(pitch_q)
                            && ar1_q == $past(ar1_q) + $past(pitch_q)));
endmodule

bind ckbd_agu ckbd_agu_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_i         (op_i),
    .opnd_a_i     (opnd_a_i),
    .opnd_b_i     (opnd_b_i),
    .bank0_addr_o (bank0_addr_o),
    .bank1_addr_o (bank1_addr_o),
    .ar0_q        (ar0_q),
    .ar1_q        (ar1_q),
    .ring_lo_q    (ring_lo_q),
    .ring_hi_q    (ring_hi_q),
    .pitch_q      (pitch_q),
    .xm_q         (xm_q),
    .ym_q         (ym_q)
);

// File: tb/sim_ckbd_agu.sv
`timescale 1ns/1ps
module sim_ckbd_agu;
    localparam int AW   = 16;
    localparam int MASK = 32'h0000_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    op_i = 4'd0;
    logic [AW-1:0] opnd_a_i = '0;
    logic [AW-1:0] opnd_b_i = '0;
    logic [AW-1:0] bank0_addr_o, bank1_addr_o;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_ar0 = 0, m_ar1 = 0, m_lo = 0, m_hi = 0, m_pitch = 0, m_xm = 0, m_ym = 0;

    always #2 clk = ~clk;

    ckbd_agu #(.AW(AW)) u0 (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op_i),
        .opnd_a_i     (opnd_a_i),
        .opnd_b_i     (opnd_b_i),
        .bank0_addr_o (bank0_addr_o),
        .bank1_addr_o (bank1_addr_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int op, input int a, input int b, input string tag);
        int e0, e1, p0, p1, st;
        @(negedge clk);
        op_i     = 4'(op);
        opnd_a_i = AW'(a);
        opnd_b_i = AW'(b);
        #1;
        e0 = m_ar0;
        e1 = m_ar1;
        if (op == 7 || op == 8) begin
            st = (op == 8) ? 1 : 0;
            p0 = (m_xm == 1 && m_ym == 0) ? 1 : 0;
            p1 = (m_xm == 1 && m_ym == 1) ? 1 : 0;
            e0 = (m_ar0 + st + p0) & MASK;
            e1 = (m_ar1 + st + p1) & MASK;
        end
        check(tag, "bank0", int'(bank0_addr_o), e0);
        check(tag, "bank1", int'(bank1_addr_o), e1);
        case (op)
            1: begin
                m_ar0 = (m_ar0 + 1) & MASK;
                if (m_ar1 == m_hi) m_ar1 = m_lo;
                else m_ar1 = (m_ar1 + 1) & MASK;
            end
            2: m_lo = a & MASK;
            3: m_hi = a & MASK;
            4: begin
                m_ar0 = (a & MASK) / 2;
                m_ar1 = (a & MASK) / 2;
                m_xm  = a % 2;
                m_ym  = b % 2;
            end
            5: begin
                m_ar0 = (m_ar0 + a) & MASK;
                m_ar1 = (m_ar1 + a) & MASK;
                m_pitch = b & MASK;
            end
            6: begin
                m_ar0 = (m_ar0 + a) & MASK;
                m_ar1 = (m_ar1 + b) & MASK;
            end
            8: begin
                m_ar0 = (m_ar0 + m_pitch) & MASK;
                m_ar1 = (m_ar1 + m_pitch) & MASK;
                m_ym  = 1 - m_ym;
            end
            default: ;
        endcase
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible through a hold
        apply(0, 0, 0, "R1");
        // R5: ring bounds
        apply(2, 100, 0, "R5");
        apply(3, 103, 0, "R5");
        // R6: pointers from x = 200
        apply(4, 200, 0, "R6");
        // R3 / R4: streaming with ring wrap at 103 -> 100
        for (int i = 0; i < 6; i++) apply(1, 0, 0, "R4");
        apply(0, 0, 0, "R3");
        // R2: hold and unused codes keep state
        apply(0, 55, 66, "R2");
        apply(15, 77, 88, "R2");
        apply(9, 11, 12, "R2");
        apply(0, 0, 0, "R2");
        // R11: wrap of pointer 0 from all ones
        apply(4, 16'hFFFE, 0, "R11");
        apply(6, 16'h8000, 16'h8040, "R8");
        apply(1, 0, 0, "R11");
        apply(0, 0, 0, "R11");
        // checkerboard, odd column x = 7, even row y = 2
        apply(4, 7, 2, "R6");
        apply(5, 2 * 64, 64, "R7");
        apply(6, 16'h1000, 16'h2000, "R8");
        for (int r = 0; r < 4; r++) begin
            apply(7, 0, 0, "R9");
            apply(8, 0, 0, "R10");
        end
        apply(0, 0, 0, "R10");
        // even column x = 4, odd row y = 1
        apply(4, 4, 1, "R6");
        apply(5, 64, 128, "R7");
        apply(6, 16'h0400, 16'h0800, "R8");
        for (int r = 0; r < 3; r++) begin
            apply(8, 0, 0, "R10");
            apply(7, 0, 0, "R9");
        end
        // odd column, odd row: bank 1 correction
        apply(4, 9, 3, "R6");
        apply(7, 0, 0, "R9");
        apply(8, 0, 0, "R10");
        apply(7, 0, 0, "R9");
        // R1: reset clears everything again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ar0 = 0; m_ar1 = 0; m_lo = 0; m_hi = 0; m_pitch = 0; m_xm = 0; m_ym = 0;
        apply(7, 0, 0, "R1");
        apply(8, 0, 0, "R1");
        apply(0, 0, 0, "R1");
        finish_run();
    end
endmodule